// File: doc/BRIEF.md
# Strobed Parallel Input/Output Port Controller

This block is the control and status register of a small parallel port. On the output side, software sets the level of a strobe output pin directly through a control bit. On the input side, an eight-bit data bus is latched into a holding buffer whenever the external input strobe makes its selected transition. The buffer can also be switched off, and then software reads the live pins.

The input strobe, an interrupt input and the data pins each pass through a two-stage synchronizer. Edge detection and capture both work on the synchronized values. Software chooses which strobe edge captures data and can clear the buffer with a self-clearing command bit. Two read-only status bits report the synchronized strobe level and the interrupt input, the latter corrected for a programmable polarity.

Access is through a simple register bus. There is one address and one write enable, 32-bit write and read data, and reads return their data one clock after the address is presented.

Top module: `pio_port`

## Requirements
- R1: The control register is at offset 0x40 and uses these bits: 0 output strobe level, 1 buffer enable, 2 capture-edge select, 3 buffer clear, 4 interrupt polarity, 5 interrupt status, 6 strobe status. The input data register is at offset 0x44, with the data in bits [7:0].
- R2: Bits 31..7 of the control register, and bits 31..8 of the data register, always read 0. Write data in bits 31..7 and in the read-only bits 5 and 6 has no effect.
- R3: After a write to the control register, `strobeOut` equals the written bit 0 from the following cycle on.
- R4: With bit 1 set, each selected strobe edge loads the synchronized pins into the buffer. Reads of offset 0x44 then return the buffer, which holds its value when the pins change later.
- R5: With bit 1 clear, strobe edges load nothing. Reads of offset 0x44 return the synchronized pins.
- R6: When bit 2 is 0, the rising edge of the synchronized strobe captures data. When bit 2 is 1, the falling edge captures. The other edge never captures.
- R7: Writing 1 to bit 3 zeroes the buffer at that same clock edge. Bit 3 always reads 0.
- R8: Bit 5 reads the synchronized interrupt input XOR bit 4. Bit 6 reads the synchronized strobe input level.
- R9: After reset, control bits 0, 1, 2 and 4 are 0, `strobeOut` is 0 and the buffer is 0.
- R10: `busRdata` shows the register selected by `busAddr` as it stood at the previous clock edge. A read in the same cycle as a write therefore returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle latency |
| strobeOut | output | 1 | Software-driven strobe output level |
| inStrobe | input | 1 | External input strobe (asynchronous) |
| irqIn | input | 1 | External interrupt input (asynchronous) |
| inPins | input | 8 | Parallel input data pins (asynchronous) |

## Verification
The bench builds the block with its defaults: an eight-bit data bus and two synchronizer stages. With these values every one of the 256 pin patterns can be swept through the bypass path at a few cycles each. For both edge polarities, a stride through the pattern space checks capture on the selected edge and rejection of the opposite edge. The four combinations of interrupt level and polarity, the self-clearing command and the read-before-write latency are each checked directly.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // control register bit positions
  localparam int BIT_LVL    = 0;
  localparam int BIT_BUFEN  = 1;
  localparam int BIT_FALL   = 2;
  localparam int BIT_CLR    = 3;
  localparam int BIT_IPOL   = 4;
  localparam int BIT_ISTAT  = 5;
  localparam int BIT_SSTAT  = 6;
  localparam int CTRL_BITS  = 7;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic bufEn;     // buffered mode
    logic fallEdge;  // capture on falling edge
    logic clearBuf;  // one-cycle clear command
  } pioStrobes_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobes_t       ctl,
  input  logic              inStrobe,
  input  logic              irqIn,
  input  logic [DATA_W-1:0] inPins,
  output logic [DATA_W-1:0] dataView,
  output logic              strobeLvl,
  output logic              irqLvl
);
  localparam int SW = DATA_W + 2;

  logic [SW-1:0]     syncOut;
  logic [DATA_W-1:0] pinSync;
  logic              stbSync;
  logic              stbPrev;
  logic              rise;
  logic              fall;
  logic              hit;
  logic [DATA_W-1:0] capBuf;

  pio_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({irqIn, inStrobe, inPins}),
    .q   (syncOut)
  );

  assign pinSync = syncOut[DATA_W-1:0];
  assign stbSync = syncOut[DATA_W];
  assign irqLvl  = syncOut[DATA_W+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbPrev <= 1'b0;
    else       stbPrev <= stbSync;
  end

  assign rise = stbSync & ~stbPrev;
  assign fall = ~stbSync & stbPrev;
  assign hit  = ctl.fallEdge ? fall : rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   capBuf <= '0;
    else if (ctl.clearBuf)       capBuf <= '0;
    else if (ctl.bufEn && hit)   capBuf <= pinSync;
  end

  assign dataView  = ctl.bufEn ? capBuf : pinSync;
  assign strobeLvl = stbSync;

  AST_BYPASS_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.bufEn && !ctl.clearBuf) |=> $stable(capBuf)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearBuf |=> (capBuf == '0)); // R7
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && !ctl.clearBuf) |=> $stable(capBuf)); // R6
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  CTRL_OFS = 8'h40,
  parameter logic [7:0]  DATA_OFS = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [DATA_W-1:0] dataView,
  input  logic              strobeLvl,
  input  logic              irqLvl,
  output pioStrobes_t       ctl,
  output logic              strobeOut
);
  localparam int PAD_C = 32 - CTRL_BITS;
  localparam int PAD_D = 32 - DATA_W;

  logic        ctrlWr;
  logic        lvlReg;
  logic        enReg;
  logic        fallReg;
  logic        ipolReg;
  logic [31:0] ctrlView;
  logic [31:0] dataRd;
  logic [31:0] rdNext;

  assign ctrlWr = busWe && (busAddr == ADDR_W'(CTRL_OFS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlReg  <= 1'b0;
      enReg   <= 1'b0;
      fallReg <= 1'b0;
      ipolReg <= 1'b0;
    end else if (ctrlWr) begin
      lvlReg  <= busWdata[BIT_LVL];
      enReg   <= busWdata[BIT_BUFEN];
      fallReg <= busWdata[BIT_FALL];
      ipolReg <= busWdata[BIT_IPOL];
    end
  end

  assign ctl.bufEn    = enReg;
  assign ctl.fallEdge = fallReg;
  assign ctl.clearBuf = ctrlWr && busWdata[BIT_CLR];
  assign strobeOut    = lvlReg;

  always_comb begin
    ctrlView            = '0;
    ctrlView[BIT_LVL]   = lvlReg;
    ctrlView[BIT_BUFEN] = enReg;
    ctrlView[BIT_FALL]  = fallReg;
    ctrlView[BIT_IPOL]  = ipolReg;
    ctrlView[BIT_ISTAT] = irqLvl ^ ipolReg;
    ctrlView[BIT_SSTAT] = strobeLvl;
  end

  assign dataRd = {{PAD_D{1'b0}}, dataView};

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_OFS))      rdNext = ctrlView;
    else if (busAddr == ADDR_W'(DATA_OFS)) rdNext = dataRd;
    else                                   rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) == ADDR_W'(CTRL_OFS)) |-> (busRdata[31:CTRL_BITS] == '0)); // R2
  AST_RSV_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (|busWdata[31:BIT_IPOL])) |=> (busRdata[31:CTRL_BITS] == '0)); // R2
  AST_STROBE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (strobeOut == $past(busWdata[BIT_LVL]))); // R3
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) == ADDR_W'(CTRL_OFS)) |-> !busRdata[BIT_CLR]); // R7
  AST_PAD_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) == ADDR_W'(DATA_OFS)) |-> (busRdata[31:DATA_W] == '0)); // R1
  initial assert (PAD_C > 0 && PAD_D > 0);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_OFS    = 8'h40,
  parameter logic [7:0] DATA_OFS    = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              strobeOut,
  input  logic              inStrobe,
  input  logic              irqIn,
  input  logic [DATA_W-1:0] inPins
);
  pioStrobes_t       ctl;
  logic [DATA_W-1:0] dataView;
  logic              strobeLvl;
  logic              irqLvl;

  pio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .dataView (dataView),
    .strobeLvl(strobeLvl),
    .irqLvl   (irqLvl),
    .ctl      (ctl),
    .strobeOut(strobeOut)
  );

  pio_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inStrobe (inStrobe),
    .irqIn    (irqIn),
    .inPins   (inPins),
    .dataView (dataView),
    .strobeLvl(strobeLvl),
    .irqLvl   (irqLvl)
  );
endmodule

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] DATA = 8'h44;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        strobeOut;
  logic        inStrobe = 1'b0;
  logic        irqIn = 1'b0;
  logic [7:0]  inPins = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pio_port i_pio_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .strobeOut(strobeOut),
    .inStrobe(inStrobe), .irqIn(irqIn), .inPins(inPins)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected control view
  function automatic logic [31:0] ctrlExp(input logic lvl, en, fall, ipol, irq, stb);
    return {25'd0, stb, irq ^ ipol, ipol, 1'b0, fall, en, lvl};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    settle(3);
    rstN = 1'b1;
    settle(2);

    // R9: reset state
    rd(CTRL, r);
    check("R9 ctrl after reset", r, 32'h0);
    check("R9 strobeOut after reset", {31'd0, strobeOut}, 32'h0);
    wr(CTRL, 32'h2);
    rd(DATA, r);
    check("R9 buffer after reset", r, 32'h0);
    wr(CTRL, 32'h0);

    // R3: strobe output level
    wr(CTRL, 32'h1);
    check("R3 strobeOut high", {31'd0, strobeOut}, 32'h1);
    wr(CTRL, 32'h0);
    check("R3 strobeOut low", {31'd0, strobeOut}, 32'h0);

    // R10: read in write cycle returns old value, next cycle new
    @(negedge clk);
    busAddr = CTRL; busWe = 1'b1; busWdata = 32'h1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
    check("R10 read during write is old", busRdata, 32'h0);
    @(negedge clk);
    check("R10 read after write is new", busRdata, 32'h1);
    wr(CTRL, 32'h0);

    // R1 R2: all ones written; reserved and RO bits ignored, clear reads 0
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, r);
    check("R2 R1 ctrl after all-ones write", r, ctrlExp(1, 1, 1, 1, 0, 0));
    check("R7 clear bit reads zero", {31'd0, r[3]}, 32'h0);
    wr(CTRL, 32'h0);
    rd(8'h48, r);
    check("R2 unmapped offset reads zero", r, 32'h0);

    // R8: interrupt status over level x polarity, strobe status
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 2; l++) begin
        irqIn = l[0];
        wr(CTRL, {27'd0, p[0], 4'd0});
        settle(3);
        rd(CTRL, r);
        check("R8 irq status", r, ctrlExp(0, 0, 0, p[0], l[0], 0));
      end
    end
    irqIn = 1'b0;
    wr(CTRL, 32'h0);
    inStrobe = 1'b1; settle(3);
    rd(CTRL, r);
    check("R8 strobe status high", r, ctrlExp(0, 0, 0, 0, 0, 1));
    inStrobe = 1'b0; settle(3);
    rd(CTRL, r);
    check("R8 strobe status low", r, ctrlExp(0, 0, 0, 0, 0, 0));

    // R5: bypass reads live pins, all 256 patterns
    for (int v = 0; v < 256; v++) begin
      inPins = v[7:0];
      settle(3);
      rd(DATA, r);
      check("R5 bypass pins", r, {24'd0, v[7:0]});
    end
    // R5: strobe pulses in bypass mode load nothing
    wr(CTRL, 32'h8); // clear buffer, bypass
    inPins = 8'hA5;
    inStrobe = 1'b1; settle(4);
    inStrobe = 1'b0; settle(4);
    wr(CTRL, 32'h2);
    rd(DATA, r);
    check("R5 bypass strobe ignored", r, 32'h0);

    // R4 R6: capture on selected edge, opposite edge ignored
    for (int p = 0; p < 2; p++) begin
      logic idle;
      idle = p[0];
      wr(CTRL, {29'd0, p[0], 2'b10});
      inStrobe = idle; settle(4);
      for (int v = 1; v < 256; v += 23) begin
        inPins = v[7:0];
        settle(3);
        inStrobe = ~idle; settle(4);
        inPins = ~v[7:0]; settle(4);
        rd(DATA, r);
        check("R4 captured on selected edge", r, {24'd0, v[7:0]});
        inStrobe = idle; settle(4);
        rd(DATA, r);
        check("R6 opposite edge ignored", r, {24'd0, v[7:0]});
      end
      // R7: clear zeroes buffer
      wr(CTRL, {28'd0, 1'b1, p[0], 2'b10});
      rd(DATA, r);
      check("R7 clear zeroes buffer", r, 32'h0);
      rd(CTRL, r);
      check("R7 clear self-clears", r, ctrlExp(0, 1, p[0], 0, 0, idle));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule